// File: doc/BRIEF.md
# Task-priority interrupt gate

This block holds a 64-bit task-priority register and uses it to filter a set of pending external interrupt requests. Each request belongs to one of fifteen priority classes, 1 (lowest) to 15 (highest). A request is delivered only if its class is strictly above the stored 4-bit priority. Among the deliverable classes, the gate offers the highest one to the core on a registered output with a valid flag.

Software writes and reads the register through a simple port. A write that sets any reserved bit is refused and flagged. The core retires an offered class by raising acknowledge. A request vector with one bit per class is ORed into the pending set every cycle. A two-state machine tracks the offer. In `S_IDLE` nothing is offered. In `S_OFFER` a class is presented. The transitions are `IDLE_TO_OFFER`, taken when some pending class clears the threshold; `OFFER_HOLD`, which stays in `S_OFFER` while a deliverable class remains, possibly a different one after a retirement; `OFFER_TO_IDLE`, taken when nothing is deliverable any more; and `IDLE_HOLD`.

Top module: `prio_gate`

## Requirements
- R1: Reset (active-low `rst_n`) clears the priority to 0, empties the pending set, and drives `irq_valid`, `irq_class` and `wr_err` to 0.
- R2: A write whose bits 63:4 are all zero stores bits 3:0 as the new priority. The new value is visible on `rd_data` after the next clock edge.
- R3: A write with any of bits 63:4 set leaves the priority unchanged. It raises `wr_err` for exactly the one cycle after that edge.
- R4: `rd_data` always carries the stored priority in bits 3:0, with bits 63:4 reading as zero.
- R5: Bit c of `req_vec` (c = 1..15) makes class c pending. Bit 0 names class 0, which is invalid and is never latched.
- R6: A pending class c is deliverable only when c > stored priority. A priority of 0 passes classes 1..15. A priority of 15 blocks them all.
- R7: `irq_class` shows the highest deliverable pending class while `irq_valid` is 1. When nothing is deliverable, `irq_valid` is 0 and `irq_class` is 0.
- R8: `irq_ack` while `irq_valid` is 1 clears the presented class at the next edge, and the output moves to the next deliverable class at that same edge. `irq_ack` while `irq_valid` is 0 has no effect.
- R9: If the presented class is acknowledged and requested again in the same cycle, the new request wins and the class stays pending.
- R10: A request or register write presented in one cycle is reflected on `irq_valid`/`irq_class` after the next clock edge.
- R11: A pending class that is blocked stays pending. It becomes deliverable as soon as the priority is lowered below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Register write value |
| rd_data | output | 64 | Stored priority, zero-extended |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| req_vec | input | 16 | One request bit per class, bit 0 ignored |
| irq_ack | input | 1 | Retires the presented class |
| irq_valid | output | 1 | A deliverable class is presented |
| irq_class | output | 4 | Presented class, 0 when idle |

## Verification
Two things can land on the same class in one cycle: retirement by acknowledge, and a fresh request. The bench forces this by acknowledging class 3 while also requesting class 3. It then expects class 3 to stay on the output instead of dropping to idle. The bench also makes register writes coincide with new requests. In one case it raises the priority to 15 while class 15 is requested, and expects nothing to be offered. In another it lowers the priority while blocked classes are pending, and expects the newly unblocked highest class at the very next edge.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int TPG_REG_W  = 64;
    localparam int TPG_PRIO_W = 4;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_OFFER = 1'b1
    } gate_state_e;

endpackage

// File: rtl/tpg_prio_reg.sv
module tpg_prio_reg #(
    parameter int REG_W  = 64,
    parameter int PRIO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [PRIO_W-1:0] tpr_d,
    output logic [REG_W-1:0]  rd_data,
    output logic              wr_err
);

    localparam int RSV_W = REG_W - PRIO_W;

    logic [PRIO_W-1:0] tpr_q;
    logic              rsv_hit;
    logic              wr_ok;
    logic              wr_bad;

    // Any reserved bit set refuses the write
    assign rsv_hit = |wr_data[REG_W-1:PRIO_W];
    assign wr_ok   = wr_en && !rsv_hit;
    assign wr_bad  = wr_en && rsv_hit;

    always_comb begin
        tpr_d = wr_ok ? wr_data[PRIO_W-1:0] : tpr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tpr_q  <= '0;
            wr_err <= 1'b0;
        end else begin
            tpr_q  <= tpr_d;
            wr_err <= wr_bad;
        end
    end

    assign rd_data = {{RSV_W{1'b0}}, tpr_q};

endmodule

// File: rtl/tpg_pend_bank.sv
module tpg_pend_bank #(
    parameter int NCLS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] req,
    input  logic [NCLS-1:0] clr,
    output logic [NCLS-1:0] pend_d
);

    // Class 0 is never a legal request
    localparam logic [NCLS-1:0] LIVE = ~(NCLS'(1));

    logic [NCLS-1:0] pend_q;

    // New requests win over a same-cycle retirement
    assign pend_d = (pend_q & ~clr) | (req & LIVE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/tpg_select.sv
module tpg_select #(
    parameter int PRIO_W = 4,
    parameter int NCLS   = 16
) (
    input  logic [PRIO_W-1:0] tpr,
    input  logic [NCLS-1:0]   pend,
    output logic              any,
    output logic [PRIO_W-1:0] best
);

    logic [NCLS-1:0] elig;

    // Per-class threshold comparison
    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        assign elig[g] = pend[g] && (PRIO_W'(g) > tpr);
    end

    // Ascending scan: the last hit is the highest class
    always_comb begin
        any  = |elig;
        best = '0;
        for (int c = 1; c < NCLS; c++) begin
            if (elig[c]) begin
                best = PRIO_W'(c);
            end
        end
    end

endmodule

// File: rtl/prio_gate.sv
module prio_gate
    import tpg_pkg::*;
#(
    parameter int REG_W  = TPG_REG_W,
    parameter int PRIO_W = TPG_PRIO_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [REG_W-1:0]         wr_data,
    output logic [REG_W-1:0]         rd_data,
    output logic                     wr_err,
    input  logic [(1<<PRIO_W)-1:0]   req_vec,
    input  logic                     irq_ack,
    output logic                     irq_valid,
    output logic [PRIO_W-1:0]        irq_class
);

    localparam int NCLS = 1 << PRIO_W;

    logic [PRIO_W-1:0] tpr_d;
    logic [NCLS-1:0]   pend_d;
    logic [NCLS-1:0]   clr_vec;
    logic              any_d;
    logic [PRIO_W-1:0] best_d;
    logic              retire;

    gate_state_e       state_q;
    gate_state_e       state_d;
    logic [PRIO_W-1:0] cls_q;

    tpg_prio_reg #(.REG_W(REG_W), .PRIO_W(PRIO_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .tpr_d   (tpr_d),
        .rd_data (rd_data),
        .wr_err  (wr_err)
    );

    tpg_pend_bank #(.NCLS(NCLS)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req_vec),
        .clr    (clr_vec),
        .pend_d (pend_d)
    );

    // Selection looks at next-state pending and priority so that
    // the output register never repeats a retired class
    tpg_select #(.PRIO_W(PRIO_W), .NCLS(NCLS)) u_sel (
        .tpr  (tpr_d),
        .pend (pend_d),
        .any  (any_d),
        .best (best_d)
    );

    assign retire  = (state_q == S_OFFER) && irq_ack;
    assign clr_vec = retire ? (NCLS'(1) << cls_q) : '0;

    // Transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = any_d ? S_OFFER : S_IDLE;   // IDLE_TO_OFFER / IDLE_HOLD
            S_OFFER: state_d = any_d ? S_OFFER : S_IDLE;   // OFFER_HOLD / OFFER_TO_IDLE
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cls_q   <= '0;
        end else begin
            state_q <= state_d;
            cls_q   <= any_d ? best_d : '0;
        end
    end

    // Outputs
    always_comb begin
        irq_valid = (state_q == S_OFFER);
        irq_class = cls_q;
    end

endmodule

// File: rtl/tpg_chk.sv
module tpg_chk #(
    parameter int REG_W  = 64,
    parameter int PRIO_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [REG_W-1:0]       wr_data,
    input logic [REG_W-1:0]       rd_data,
    input logic                   wr_err,
    input logic [(1<<PRIO_W)-1:0] req_vec,
    input logic                   irq_ack,
    input logic                   irq_valid,
    input logic [PRIO_W-1:0]      irq_class
);

    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(|wr_data[REG_W-1:PRIO_W]))
        |=> (rd_data[PRIO_W-1:0] == $past(wr_data[PRIO_W-1:0])) && !wr_err);

    // R3
    wr_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (|wr_data[REG_W-1:PRIO_W]))
        |=> (rd_data == $past(rd_data)) && wr_err);

    // R3
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (|wr_data[REG_W-1:PRIO_W])) |=> !wr_err);

    // R4
    rd_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:PRIO_W] == '0);

    // R6
    above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_class > rd_data[PRIO_W-1:0]));

    // R5
    no_cls0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_class != '0));

    // R7
    idle_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> (irq_class == '0));

    // R8
    retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_ack && !req_vec[irq_class])
        |=> !(irq_valid && (irq_class == $past(irq_class))));

endmodule

bind prio_gate tpg_chk #(.REG_W(REG_W), .PRIO_W(PRIO_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .wr_err    (wr_err),
    .req_vec   (req_vec),
    .irq_ack   (irq_ack),
    .irq_valid (irq_valid),
    .irq_class (irq_class)
);

// File: tb/sim_prio_gate.sv
module sim_prio_gate;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 16;

    typedef struct packed {
        logic        wr;
        logic [63:0] wd;
        logic [15:0] rq;
        logic        ack;
        logic        ev;
        logic [3:0]  ec;
        logic        ee;
        logic [3:0]  et;
    } vec_t;

    // wr, wdata, req, ack | exp valid, exp class, exp err, exp priority
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 64'h0,  16'h0001, 1'b0, 1'b0, 4'd0,  1'b0, 4'd0},  // R5 class 0 dropped
        '{1'b0, 64'h0,  16'h0028, 1'b0, 1'b1, 4'd5,  1'b0, 4'd0},  // R7 highest of 3,5
        '{1'b1, 64'h9,  16'h0000, 1'b0, 1'b0, 4'd0,  1'b0, 4'd9},  // R6 R10 write 9 blocks
        '{1'b0, 64'h0,  16'h1000, 1'b0, 1'b1, 4'd12, 1'b0, 4'd9},  // R6 12 passes
        '{1'b1, 64'h10, 16'h0000, 1'b0, 1'b1, 4'd12, 1'b1, 4'd9},  // R3 bit 4 refused
        '{1'b0, 64'h0,  16'h0000, 1'b0, 1'b1, 4'd12, 1'b0, 4'd9},  // R3 pulse ends
        '{1'b0, 64'h0,  16'h0000, 1'b1, 1'b0, 4'd0,  1'b0, 4'd9},  // R8 R11 retire 12
        '{1'b0, 64'h0,  16'h0000, 1'b1, 1'b0, 4'd0,  1'b0, 4'd9},  // R8 ack while idle
        '{1'b1, 64'h0,  16'h0000, 1'b0, 1'b1, 4'd5,  1'b0, 4'd0},  // R11 lower to 0
        '{1'b0, 64'h0,  16'h0000, 1'b1, 1'b1, 4'd3,  1'b0, 4'd0},  // R8 next class
        '{1'b0, 64'h0,  16'h0008, 1'b1, 1'b1, 4'd3,  1'b0, 4'd0},  // R9 request wins
        '{1'b1, 64'hF,  16'h8000, 1'b0, 1'b0, 4'd0,  1'b0, 4'd15}, // R6 15 blocks all
        '{1'b1, 64'h8000000000000002, 16'h0000, 1'b0, 1'b0, 4'd0, 1'b1, 4'd15}, // R3 bit 63
        '{1'b1, 64'h2,  16'h0000, 1'b0, 1'b1, 4'd15, 1'b0, 4'd2},  // R2 R11
        '{1'b0, 64'h0,  16'h0000, 1'b1, 1'b1, 4'd3,  1'b0, 4'd2},  // R8
        '{1'b0, 64'h0,  16'h0000, 1'b1, 1'b0, 4'd0,  1'b0, 4'd2}   // R8 empty
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        wr_err;
    logic [15:0] req_vec = '0;
    logic        irq_ack = 1'b0;
    logic        irq_valid;
    logic [3:0]  irq_class;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_gate u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .wr_err    (wr_err),
        .req_vec   (req_vec),
        .irq_ack   (irq_ack),
        .irq_valid (irq_valid),
        .irq_class (irq_class)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic w, input logic [63:0] d, input logic [15:0] r, input logic a);
        wr_en   = w;
        wr_data = d;
        req_vec = r;
        irq_ack = a;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", rd_data, 64'h0);
        chk("R1 irq_valid", {63'h0, irq_valid}, 64'h0);
        chk("R1 irq_class", {60'h0, irq_class}, 64'h0);
        chk("R1 wr_err", {63'h0, wr_err}, 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].wr, VEC[i].wd, VEC[i].rq, VEC[i].ack);
            step();
            chk("R7 irq_valid", {63'h0, irq_valid}, {63'h0, VEC[i].ev});
            chk("R7 irq_class", {60'h0, irq_class}, {60'h0, VEC[i].ec});
            chk("R3 wr_err", {63'h0, wr_err}, {63'h0, VEC[i].ee});
            chk("R4 rd_data", rd_data, {60'h0, VEC[i].et});
        end

        // R6 R7: priority 0, every class requested, class 0 included
        drive(1'b1, 64'h0, 16'hFFFF, 1'b0);
        step();
        chk("R6 all pass valid", {63'h0, irq_valid}, 64'h1);
        chk("R7 top class", {60'h0, irq_class}, 64'hF);
        // R6 priority 14 still passes 15
        drive(1'b1, 64'hE, 16'h0000, 1'b0);
        step();
        chk("R6 prio 14 class", {60'h0, irq_class}, 64'hF);
        chk("R2 prio 14 stored", rd_data, 64'hE);
        // R6 priority 15 blocks, pending kept
        drive(1'b1, 64'hF, 16'h0000, 1'b0);
        step();
        chk("R6 prio 15 valid", {63'h0, irq_valid}, 64'h0);

        // R1 reset mid-run clears priority and pending
        drive(1'b0, 64'h0, 16'h0000, 1'b0);
        rst_n = 1'b0;
        step();
        chk("R1 rd_data after reset", rd_data, 64'h0);
        chk("R1 valid after reset", {63'h0, irq_valid}, 64'h0);
        rst_n = 1'b1;
        step();
        chk("R1 pending cleared", {63'h0, irq_valid}, 64'h0);

        finish_run();
    end

endmodule